// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into two gate enables for a synchronous buck half-bridge: one for the high-side switch and one for the low-side switch. The two are never on together. The enables are not separated by a fixed dead time. Each turn-on waits until sense feedback confirms that the opposite switch is off, and then waits a further turn-on delay counted in clock cycles. The sense feedback comes from three digital comparator flags: low-side gate below threshold, switch node below threshold, and high-side gate-source voltage below threshold.

On a falling PWM edge there are two ways the low side can turn on. The primary path waits for the switch node to fall. A longer backup timer starts once the high-side gate has discharged. When that timer runs out, the low side turns on even if the switch node never falls, so the bootstrap capacitor is recharged on every cycle while the converter sinks current. An enable input holds both gates low while it is low. The PWM, enable and sense inputs are asynchronous, and each passes through a two-flop synchronizer before the sequencer uses it.

Signal encodings:
- `pwm_cmd` = 1 asks for the high-side phase.
- `pwm_cmd` = 0 asks for the low-side phase.
- Each sense flag is 1 when the sensed voltage is below its threshold.
- `drive_en` = 0 disables switching.

Top module: `gate_seq`

## Requirements

Latencies are counted in rising clock edges after a raw input change that is applied between edges. The parameter defaults are PROP_CYC=2, HS_ON_CYC=3, LS_ON_CYC=4 and LS_BKUP_CYC=12, with two-flop synchronizers.

- R1: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R2: When `pwm_cmd` rises, `ls_gate` falls at edge 3+PROP_CYC. `hs_gate` rises only after `lg_low` has been seen at 1. If `lg_low` was already 1, `hs_gate` rises at edge 4+PROP_CYC+HS_ON_CYC. If `lg_low` rises later, `hs_gate` rises at edge 3+HS_ON_CYC after that change.
- R3: When `pwm_cmd` falls with `sw_low`=1, `hs_gate` falls at edge 3+PROP_CYC and `ls_gate` rises at edge 4+PROP_CYC+LS_ON_CYC.
- R4: When `pwm_cmd` falls with `sw_low`=0 and `hs_vgs_low`=1, `ls_gate` rises at edge 4+PROP_CYC+LS_BKUP_CYC, whatever the state of the switch node.
- R5: When `sw_low` and `hs_vgs_low` are both 1, the primary timing of R3 sets the low-side turn-on, because LS_BKUP_CYC is larger than LS_ON_CYC.
- R6: While `drive_en` is 0, both gates are 0 from edge 3 after its fall, and `pwm_cmd` changes have no effect on either gate.
- R7: During reset both gates are 0. After `drive_en` rises, the gates follow the current `pwm_cmd` level through the normal sequence. With `pwm_cmd`=1 and `lg_low`=1, `hs_gate` rises at edge 4+HS_ON_CYC.
- R8: If `pwm_cmd` reverses before a pending turn-on completes, that turn-on is cancelled and the sequence for the new level starts. A one-cycle low pulse on `pwm_cmd` while the high side is on leaves `hs_gate` at 1.
- R9: After a falling `pwm_cmd` with `sw_low`=0 and `hs_vgs_low`=0, `ls_gate` stays 0 for as long as that lasts.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en | input | 1 | 0 holds both gates low (asynchronous) |
| pwm_cmd | input | 1 | PWM command from the controller (asynchronous) |
| lg_low | input | 1 | Low-side gate voltage below threshold |
| sw_low | input | 1 | Switch node below threshold |
| hs_vgs_low | input | 1 | High-side gate-source voltage below threshold |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification

The embedded properties assume that each sense flag is stable long enough to cross the synchronizer. They also assume that a gate only turns on when the synchronized PWM level asks for that phase. The bench meets these assumptions by changing inputs only on falling clock edges. It holds every sense flag as a static level for the whole of a transition, except in the one directed case that raises `lg_low` late. The bench never models feedback from the gates to the flags, so each path (primary, backup, missing flag) can be selected on its own.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_HS     = 3'd1,
        ST_F_PROP = 3'd2,
        ST_F_WAIT = 3'd3,
        ST_LS     = 3'd4,
        ST_R_PROP = 3'd5,
        ST_R_WAIT = 3'd6
    } seq_state_e;

    localparam int unsigned SYNC_W = 5;
    localparam int unsigned IDX_EN = 4;
    localparam int unsigned IDX_PWM = 3;
    localparam int unsigned IDX_LG = 2;
    localparam int unsigned IDX_SW = 1;
    localparam int unsigned IDX_VG = 0;

endpackage

// File: rtl/gate_seq_sync.sv
module gate_seq_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= async_in;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gate_seq_core.sv
module gate_seq_core
    import gate_seq_pkg::*;
#(
    parameter int unsigned PROP_CYC    = 2,
    parameter int unsigned HS_ON_CYC   = 3,
    parameter int unsigned LS_ON_CYC   = 4,
    parameter int unsigned LS_BKUP_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic pwm_s,
    input  logic lg_s,
    input  logic sw_s,
    input  logic vg_s,
    output logic hs_gate,
    output logic ls_gate
);
    localparam int unsigned MAX_A = (PROP_CYC > HS_ON_CYC) ? PROP_CYC : HS_ON_CYC;
    localparam int unsigned MAX_B = (LS_ON_CYC > LS_BKUP_CYC) ? LS_ON_CYC : LS_BKUP_CYC;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] PROP_LAST = CNT_W'(PROP_CYC - 1);
    localparam logic [CNT_W-1:0] HS_LAST   = CNT_W'(HS_ON_CYC - 1);
    localparam logic [CNT_W-1:0] LS_LAST   = CNT_W'(LS_ON_CYC - 1);
    localparam logic [CNT_W-1:0] BK_LAST   = CNT_W'(LS_BKUP_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt_pri;
        logic [CNT_W-1:0] cnt_sec;
        logic             arm_pri;
        logic             arm_sec;
        logic             hs;
        logic             ls;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        state:   ST_OFF,
        cnt_pri: '0,
        cnt_sec: '0,
        arm_pri: 1'b0,
        arm_sec: 1'b0,
        hs:      1'b0,
        ls:      1'b0
    };

    seq_regs_t r_d, r_q;
    logic      go_ls;

    always_comb begin
        r_d   = r_q;
        go_ls = 1'b0;
        if (!en_s) begin
            r_d = REGS_RST;
        end else begin
            case (r_q.state)
                ST_OFF: begin
                    r_d         = REGS_RST;
                    r_d.state   = pwm_s ? ST_R_WAIT : ST_F_WAIT;
                end
                ST_HS: begin
                    if (!pwm_s) begin
                        r_d.state   = ST_F_PROP;
                        r_d.cnt_pri = '0;
                    end
                end
                ST_F_PROP: begin
                    if (pwm_s) begin
                        r_d.state = ST_HS;
                    end else if (r_q.cnt_pri == PROP_LAST) begin
                        r_d       = REGS_RST;
                        r_d.state = ST_F_WAIT;
                    end else begin
                        r_d.cnt_pri = r_q.cnt_pri + 1'b1;
                    end
                end
                ST_F_WAIT: begin
                    if (pwm_s) begin
                        r_d       = REGS_RST;
                        r_d.state = ST_R_WAIT;
                    end else begin
                        // primary path: switch node low, then turn-on delay
                        if (r_q.arm_pri) begin
                            if (r_q.cnt_pri == LS_LAST) go_ls = 1'b1;
                            else r_d.cnt_pri = r_q.cnt_pri + 1'b1;
                        end else if (sw_s) begin
                            r_d.arm_pri = 1'b1;
                            r_d.cnt_pri = '0;
                        end
                        // backup path: high-side gate discharged, longer delay
                        if (r_q.arm_sec) begin
                            if (r_q.cnt_sec == BK_LAST) go_ls = 1'b1;
                            else r_d.cnt_sec = r_q.cnt_sec + 1'b1;
                        end else if (vg_s) begin
                            r_d.arm_sec = 1'b1;
                            r_d.cnt_sec = '0;
                        end
                        if (go_ls) begin
                            r_d       = REGS_RST;
                            r_d.state = ST_LS;
                        end
                    end
                end
                ST_LS: begin
                    if (pwm_s) begin
                        r_d.state   = ST_R_PROP;
                        r_d.cnt_pri = '0;
                    end
                end
                ST_R_PROP: begin
                    if (!pwm_s) begin
                        r_d.state = ST_LS;
                    end else if (r_q.cnt_pri == PROP_LAST) begin
                        r_d       = REGS_RST;
                        r_d.state = ST_R_WAIT;
                    end else begin
                        r_d.cnt_pri = r_q.cnt_pri + 1'b1;
                    end
                end
                ST_R_WAIT: begin
                    if (!pwm_s) begin
                        r_d       = REGS_RST;
                        r_d.state = ST_F_WAIT;
                    end else if (r_q.arm_pri) begin
                        if (r_q.cnt_pri == HS_LAST) begin
                            r_d       = REGS_RST;
                            r_d.state = ST_HS;
                        end else begin
                            r_d.cnt_pri = r_q.cnt_pri + 1'b1;
                        end
                    end else if (lg_s) begin
                        r_d.arm_pri = 1'b1;
                        r_d.cnt_pri = '0;
                    end
                end
                default: r_d = REGS_RST;
            endcase
        end
        r_d.hs = (r_d.state == ST_HS) || (r_d.state == ST_F_PROP);
        r_d.ls = (r_d.state == ST_LS) || (r_d.state == ST_R_PROP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign hs_gate = r_q.hs;
    assign ls_gate = r_q.ls;

    // R1
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R6
    disable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (!hs_gate && !ls_gate));

    // R2
    hs_rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> ($past(pwm_s) && !$past(ls_gate)));

    // R3
    ls_rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> (!$past(pwm_s) && !$past(hs_gate)));

    // R9
    ls_rise_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> $past(r_q.arm_pri || r_q.arm_sec));
endmodule

// File: rtl/gate_seq.sv
module gate_seq
    import gate_seq_pkg::*;
#(
    parameter int unsigned PROP_CYC    = 2,
    parameter int unsigned HS_ON_CYC   = 3,
    parameter int unsigned LS_ON_CYC   = 4,
    parameter int unsigned LS_BKUP_CYC = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en,
    input  logic pwm_cmd,
    input  logic lg_low,
    input  logic sw_low,
    input  logic hs_vgs_low,
    output logic hs_gate,
    output logic ls_gate
);
    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn;

    assign raw_in = {drive_en, pwm_cmd, lg_low, sw_low, hs_vgs_low};

    gate_seq_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (syn)
    );

    gate_seq_core #(
        .PROP_CYC    (PROP_CYC),
        .HS_ON_CYC   (HS_ON_CYC),
        .LS_ON_CYC   (LS_ON_CYC),
        .LS_BKUP_CYC (LS_BKUP_CYC)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s    (syn[IDX_EN]),
        .pwm_s   (syn[IDX_PWM]),
        .lg_s    (syn[IDX_LG]),
        .sw_s    (syn[IDX_SW]),
        .vg_s    (syn[IDX_VG]),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );
endmodule

// File: tb/gate_seq_tb.sv
`timescale 1ns/1ps
module gate_seq_tb;
    localparam int PROP = 2;
    localparam int HSON = 3;
    localparam int LSON = 4;
    localparam int BKUP = 12;
    localparam int OFF_E = 3 + PROP;
    localparam int HS_E  = 4 + PROP + HSON;
    localparam int LS_E  = 4 + PROP + LSON;
    localparam int BK_E  = 4 + PROP + BKUP;
    localparam int LIMIT = 40;

    // fields: pwm, lg, sw, vg, off edge, on edge
    localparam logic [19:0] VEC [6] = '{
        {4'b1100, 8'(OFF_E), 8'(HS_E)},   // R2 rise, lg already low
        {4'b0011, 8'(OFF_E), 8'(LS_E)},   // R5 fall, both paths
        {4'b1100, 8'(OFF_E), 8'(HS_E)},   // R2
        {4'b0001, 8'(OFF_E), 8'(BK_E)},   // R4 backup only
        {4'b1100, 8'(OFF_E), 8'(HS_E)},   // R2
        {4'b0010, 8'(OFF_E), 8'(LS_E)}    // R3 primary only
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drive_en = 1'b0, pwm_cmd = 1'b0, lg_low = 1'b0, sw_low = 1'b0, hs_vgs_low = 1'b0;
    logic hs_gate, ls_gate;
    int total = 0, bad = 0, overlap = 0, ls_seen = 0;

    always #4 clk = ~clk;

    gate_seq #(.PROP_CYC(PROP), .HS_ON_CYC(HSON), .LS_ON_CYC(LSON), .LS_BKUP_CYC(BKUP)) u_dut (
        .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .pwm_cmd(pwm_cmd),
        .lg_low(lg_low), .sw_low(sw_low), .hs_vgs_low(hs_vgs_low),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    always @(negedge clk) begin
        if (hs_gate && ls_gate) overlap++;
        if (ls_gate) ls_seen++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input bit to_hs, output int off_n, output int on_n);
        off_n = 0;
        on_n  = 0;
        for (int n = 1; n <= LIMIT; n++) begin
            @(posedge clk); #1;
            if (off_n == 0 && !(to_hs ? ls_gate : hs_gate)) off_n = n;
            if (to_hs ? hs_gate : ls_gate) begin
                on_n = n;
                break;
            end
        end
    endtask

    task automatic edges_to(input bit sel_hs, input bit val, output int cnt);
        cnt = 0;
        for (int n = 1; n <= LIMIT; n++) begin
            @(posedge clk); #1;
            if ((sel_hs ? hs_gate : ls_gate) == val) begin
                cnt = n;
                break;
            end
        end
    endtask

    initial begin
        #1600000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int off_n, on_n, cnt, hs_hi;
        // R7 reset state
        repeat (4) @(posedge clk);
        #1;
        chk("R7 hs in reset", hs_gate, 0);
        chk("R7 ls in reset", ls_gate, 0);
        @(negedge clk);
        rst_n = 1'b1;
        sw_low = 1'b1; hs_vgs_low = 1'b1; lg_low = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 idle while disabled", hs_gate | ls_gate, 0);
        drive_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R7 settles low side", ls_gate, 1);

        // table of transitions
        foreach (VEC[i]) begin
            @(negedge clk);
            lg_low = VEC[i][18]; sw_low = VEC[i][17]; hs_vgs_low = VEC[i][16];
            pwm_cmd = VEC[i][19];
            measure(VEC[i][19], off_n, on_n);
            chk($sformatf("R%0d vec%0d off edge", VEC[i][19] ? 2 : 3, i), off_n, int'(VEC[i][15:8]));
            chk($sformatf("R%0d vec%0d on edge", VEC[i][19] ? 2 : 3, i), on_n, int'(VEC[i][7:0]));
            repeat (5) @(negedge clk);
        end

        // R2 late lg_low: now in low-side phase
        @(negedge clk);
        lg_low = 1'b0;
        pwm_cmd = 1'b1;
        edges_to(1'b0, 1'b0, cnt);
        chk("R2 ls off without lg", cnt, OFF_E);
        repeat (LIMIT) @(negedge clk);
        chk("R2 hs waits for lg", hs_gate, 0);
        lg_low = 1'b1;
        edges_to(1'b1, 1'b1, cnt);
        chk("R2 hs after late lg", cnt, 3 + HSON);

        // R8 one-cycle low pulse on pwm keeps high side on
        repeat (5) @(negedge clk);
        pwm_cmd = 1'b0;
        @(negedge clk);
        pwm_cmd = 1'b1;
        hs_hi = 0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (hs_gate) hs_hi++;
        end
        chk("R8 glitch ignored", hs_hi, 20);

        // R9 no sense flag: low side waits; R8 reversal cancels it
        sw_low = 1'b0; hs_vgs_low = 1'b0;
        ls_seen = 0;
        pwm_cmd = 1'b0;
        edges_to(1'b1, 1'b0, cnt);
        chk("R9 hs off", cnt, OFF_E);
        repeat (LIMIT) @(negedge clk);
        chk("R9 ls held off", ls_seen, 0);
        pwm_cmd = 1'b1;
        edges_to(1'b1, 1'b1, cnt);
        chk("R8 reversal to high side", cnt, 4 + HSON);
        chk("R8 ls never on", ls_seen, 0);

        // R6 disable while high side on, pwm toggling ignored
        repeat (5) @(negedge clk);
        sw_low = 1'b1; hs_vgs_low = 1'b1;
        drive_en = 1'b0;
        edges_to(1'b1, 1'b0, cnt);
        chk("R6 disable latency", cnt, 3);
        ls_seen = 0;
        hs_hi = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            pwm_cmd = n[2];
            if (hs_gate) hs_hi++;
        end
        chk("R6 hs held low", hs_hi, 0);
        chk("R6 ls held low", ls_seen, 0);

        // R7 re-enable follows pwm level
        pwm_cmd = 1'b1;
        repeat (4) @(negedge clk);
        drive_en = 1'b1;
        edges_to(1'b1, 1'b1, cnt);
        chk("R7 re-enable high side", cnt, 4 + HSON);

        repeat (5) @(negedge clk);
        chk("R1 overlap cycles", overlap, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule